// File: doc/BRIEF.md
# Link-on wake signal generator

This block tells a sleeping link-layer controller to power up. It drives a single wake output with a square wave of about 163 ns period. The wave runs while a wake request is pending and the link is inactive. The link counts as active only when two inputs are both high: the power-status indication and the link-control bit.

A wake request is set by one of two wake events, which count only while the link is inactive:
- a single-cycle pulse for a received link-on packet addressed to this node;
- a level-sensitive PHY interrupt-pending flag.

Once set, the request is sticky. It is withdrawn in either of two ways:
- the link becomes active;
- a bus-reset pulse arrives while no interrupt is pending.

The half-period length in clock cycles is computed from two parameters, the clock period and the target half period. Decoding packets and raising interrupts happen outside this block.

Top module: `linkon_wake`

## Requirements
- R1: During and directly after reset, `wake_out` is 0.
- R2: The half period in cycles is HALF = round(`HALF_WAVE_PS` / `CLK_PERIOD_PS`), and never less than 1. With the defaults (5000 ps, 81500 ps), HALF is 16. When a request sets, `wake_out` goes to 1 on that same clock edge. It then alternates, with each level lasting exactly HALF cycles.
- R3: When the rounded ratio is 0, HALF is clamped to 1, and `wake_out` toggles on every cycle while a request is pending.
- R4: A one-cycle `linkon_pkt` pulse while `pwr_good` is 0 sets a sticky request. The wave keeps running after the pulse ends.
- R5: When `link_ctl` is 0 the link is inactive even if `pwr_good` is 1, so a `linkon_pkt` pulse sets the request.
- R6: `phy_irq` high while the link is inactive sets the request. The request stays set after `phy_irq` falls.
- R7: While `pwr_good` and `link_ctl` are both 1, `linkon_pkt` and `phy_irq` have no effect, and `wake_out` stays 0.
- R8: In the cycle after `pwr_good` and `link_ctl` are both sampled 1, the request is cleared and `wake_out` is 0.
- R9: A `bus_reset` pulse sampled while `phy_irq` is 0 clears the request, and `wake_out` is 0 in the next cycle. This holds even when `linkon_pkt` is high in the same cycle.
- R10: A `bus_reset` pulse sampled while `phy_irq` is 1 and the link is inactive leaves the wave running without a restart of its phase.
- R11: Whenever no request is pending, `wake_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Power-status indication, already qualified |
| link_ctl | input | 1 | Link-control bit |
| linkon_pkt | input | 1 | One-cycle pulse for a link-on packet addressed to this node |
| phy_irq | input | 1 | PHY interrupt pending (level) |
| bus_reset | input | 1 | One-cycle bus-reset pulse |
| wake_out | output | 1 | Wake square wave; 0 when idle |

## Verification
The bench builds two copies of the block and drives both with the same stimulus.

The first copy uses the default 5000 ps clock period. Its HALF of 16 cycles exercises rounding down from 16.3 and the full-length first level after each set.

The second copy uses a 200000 ps clock period. Its ratio rounds to 0, which reaches the clamp to one cycle, where the output toggles on every edge.

Both copies are compared every cycle against a behavioural model. The stimulus covers every set path, every clear path and their same-cycle collisions.

// File: rtl/linkon_wake.sv
module linkon_wake #(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int HALF_WAVE_PS  = 81500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic link_ctl,
  input  logic linkon_pkt,
  input  logic phy_irq,
  input  logic bus_reset,
  output logic wake_out
);

  localparam int HALF_RAW = (HALF_WAVE_PS + CLK_PERIOD_PS / 2) / CLK_PERIOD_PS;
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int CW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          req_q, req_d;
  logic [CW-1:0] cnt_q;
  logic          link_up, wake_evt;

  assign link_up  = pwr_good & link_ctl;
  assign wake_evt = linkon_pkt | phy_irq;

  always_comb begin
    req_d = req_q;
    if (link_up)        req_d = 1'b0;
    else if (bus_reset) req_d = phy_irq;
    else if (wake_evt)  req_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      cnt_q    <= '0;
      wake_out <= 1'b0;
    end else begin
      req_q <= req_d;
      if (!req_d) begin
        cnt_q    <= '0;
        wake_out <= 1'b0;
      end else if (!req_q) begin
        cnt_q    <= '0;
        wake_out <= 1'b1;
      end else if (cnt_q == LAST) begin
        cnt_q    <= '0;
        wake_out <= ~wake_out;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> !wake_out);

  a_r8_link_up_clears: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |=> !wake_out);

  a_r9_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !phy_irq) |=> !wake_out);

  a_r7_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(wake_evt && !link_up)) |=> !wake_out);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r2_hold_mid_half: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && req_d && cnt_q != LAST) |=> $stable(wake_out));

endmodule

// File: tb/linkon_wake_bench.sv
`timescale 1ns/1ps
module linkon_wake_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, link_ctl = 1'b0, linkon_pkt = 1'b0, phy_irq = 1'b0, bus_reset = 1'b0;
  logic out_def, out_fast;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_req  [2];
  int m_out  [2];
  int m_age  [2];
  int m_half [2];

  always #2.5 clk = ~clk;

  linkon_wake u_linkon_wake (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .link_ctl(link_ctl),
    .linkon_pkt(linkon_pkt), .phy_irq(phy_irq), .bus_reset(bus_reset),
    .wake_out(out_def));

  linkon_wake #(.CLK_PERIOD_PS(200000), .HALF_WAVE_PS(81500)) u_linkon_wake_fast (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .link_ctl(link_ctl),
    .linkon_pkt(linkon_pkt), .phy_irq(phy_irq), .bus_reset(bus_reset),
    .wake_out(out_fast));

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      int nreq;
      if (!rst_n) begin
        m_req[i] = 0; m_out[i] = 0; m_age[i] = 0;
      end else begin
        nreq = m_req[i];
        if (pwr_good && link_ctl)         nreq = 0;
        else if (bus_reset)               nreq = phy_irq ? 1 : 0;
        else if (linkon_pkt || phy_irq)   nreq = 1;
        if (nreq == 0) begin
          m_out[i] = 0; m_age[i] = 0;
        end else if (m_req[i] == 0) begin
          m_out[i] = 1; m_age[i] = 1;
        end else if (m_age[i] == m_half[i]) begin
          m_out[i] = 1 - m_out[i]; m_age[i] = 1;
        end else begin
          m_age[i]++;
        end
        m_req[i] = nreq;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (int'(out_def) != m_out[0]) begin
      failures++;
      $display("FAIL %s default: wake_out=%0d expected=%0d at %0t", cur_req, out_def, m_out[0], $time);
    end
    checks++;
    if (int'(out_fast) != m_out[1]) begin
      failures++;
      $display("FAIL R3 %s clamped: wake_out=%0d expected=%0d at %0t", cur_req, out_fast, m_out[1], $time);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      linkon_pkt = 1'b0;
      bus_reset  = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_half[0] = 16;
    m_half[1] = 1;
    for (int i = 0; i < 2; i++) begin m_req[i] = 0; m_out[i] = 0; m_age[i] = 0; end
    @(negedge clk);
    cur_req = "R1";
    step(4);
    rst_n = 1'b1;
    step(3);

    cur_req = "R7";
    pwr_good = 1; link_ctl = 1;
    linkon_pkt = 1; step(1);
    phy_irq = 1; step(6);
    phy_irq = 0; step(3);

    cur_req = "R4 R2";
    pwr_good = 0;
    step(2);
    linkon_pkt = 1; step(1);
    step(80);

    cur_req = "R8";
    pwr_good = 1; step(5);

    cur_req = "R5";
    link_ctl = 0; step(3);
    linkon_pkt = 1; step(1);
    step(40);
    cur_req = "R8";
    link_ctl = 1; step(4);

    cur_req = "R6";
    link_ctl = 0;
    phy_irq = 1; step(10);
    phy_irq = 0; step(40);

    cur_req = "R9";
    bus_reset = 1; step(1);
    step(10);

    cur_req = "R10";
    phy_irq = 1; step(7);
    bus_reset = 1; step(1);
    step(40);
    cur_req = "R9";
    phy_irq = 0; step(5);
    bus_reset = 1; step(1);
    step(5);

    cur_req = "R9 R11";
    linkon_pkt = 1; bus_reset = 1; step(1);
    step(10);

    cur_req = "R8 R7";
    pwr_good = 1; link_ctl = 1;
    phy_irq = 1; linkon_pkt = 1; step(1);
    step(5);
    phy_irq = 0;

    cur_req = "R1";
    link_ctl = 0; linkon_pkt = 1; step(1);
    step(5);
    rst_n = 0; step(3);
    rst_n = 1;
    cur_req = "R11";
    step(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule